// File: doc/BRIEF.md
# Three-Heads Coin Game Scorer

This block scores a coin-tossing game one toss per clock cycle. A toss code comes in every cycle: a head, a tail, or nothing. The block counts consecutive heads, and the third head in a row wins. A tail that arrives before the third head loses. After a win or a loss the count drops back to zero, so the next game starts on the following toss. A cycle with no toss leaves the count unchanged and gives no result.

The block is a Mealy machine with a registered output. The result of a transition is written into the output register on the same edge that updates the state, so the result appears one cycle after the toss that caused it. The current count of heads is brought out as a port for debug.

Top module: `coin_game_fsm`

## Requirements
- R1: A synchronous active-high reset sets the streak to zero (streak code 00) and sets the result to none (result code 00). Both values show on the first sampled cycle after the reset edge.
- R2: The toss input is 2 bits wide: 00 means no toss, 01 means head, 10 means tail, and 11 is treated exactly like 00.
- R3: The result output is 2 bits wide: 00 means none, 01 means win, 10 means lose. The value 11 never appears.
- R4: A head with a streak of zero or one adds one to the streak and gives result none. The streak codes are 00 for zero heads, 01 for one head and 10 for two heads.
- R5: A head with a streak of two sets the streak to zero and gives result win.
- R6: A tail in any state sets the streak to zero and gives result lose.
- R7: A no-toss code (00 or 11) keeps the streak unchanged and gives result none.
- R8: The result for a toss appears on the result port in the cycle after that toss is sampled. For the toss sequence tail, head, head, head the results are lose, none, none, win.
- R9: The streak never takes the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| toss_i | input | 2 | Toss code: 00 none, 01 head, 10 tail, 11 none |
| result_o | output | 2 | Registered result: 00 none, 01 win, 10 lose |
| streak_o | output | 2 | Debug view of the number of consecutive heads seen |

## Verification
Assertions check on every cycle that the streak stays legal, that the result code is legal, and that each registered result matches the streak and toss from the cycle before. This covers win, lose, advance and hold. They also check that the result returns to none when reset is applied.

Only the bench scenarios show end-to-end behaviour over a whole stream of tosses. These are the directed sequence tail, head, head, head, long no-toss gaps in the middle of a streak, back-to-back wins, and the 11 code, all compared with an independent model over random streams.

// File: rtl/coin_game_pkg.sv
package coin_game_pkg;
    localparam int TOSS_W   = 2;
    localparam int RESULT_W = 2;
    localparam int STREAK_W = 2;
    localparam int WIN_RUN  = 3;

    typedef enum logic [TOSS_W-1:0] {
        TOSS_NONE = 2'b00,
        TOSS_HEAD = 2'b01,
        TOSS_TAIL = 2'b10,
        TOSS_RSVD = 2'b11
    } toss_e;

    typedef enum logic [RESULT_W-1:0] {
        RES_NONE = 2'b00,
        RES_WIN  = 2'b01,
        RES_LOSE = 2'b10
    } result_e;

    typedef enum logic [STREAK_W-1:0] {
        ST_ZERO = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10
    } streak_e;

    typedef struct packed {
        streak_e streak;
        result_e result;
    } game_regs_t;
endpackage

// File: rtl/toss_decoder.sv
module toss_decoder
    import coin_game_pkg::*;
(
    input  logic [TOSS_W-1:0] toss_i,
    output logic              is_head_o,
    output logic              is_tail_o
);
    always_comb begin
        is_head_o = 1'b0;
        is_tail_o = 1'b0;
        unique case (toss_i)
            TOSS_HEAD: is_head_o = 1'b1;
            TOSS_TAIL: is_tail_o = 1'b1;
            default: begin
                is_head_o = 1'b0;   // R2: code 11 is treated like code 00
                is_tail_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/game_next_logic.sv
module game_next_logic
    import coin_game_pkg::*;
(
    input  streak_e    streak_i,
    input  logic       is_head_i,
    input  logic       is_tail_i,
    output game_regs_t next_o
);
    always_comb begin
        next_o.streak = streak_i;
        next_o.result = RES_NONE;
        if (is_tail_i) begin
            next_o.streak = ST_ZERO;
            next_o.result = RES_LOSE;
        end else if (is_head_i) begin
            unique case (streak_i)
                ST_ZERO: next_o.streak = ST_ONE;
                ST_ONE:  next_o.streak = ST_TWO;
                default: begin
                    next_o.streak = ST_ZERO;
                    next_o.result = RES_WIN;
                end
            endcase
        end
    end
endmodule

// File: rtl/coin_game_fsm.sv
module coin_game_fsm
    import coin_game_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [TOSS_W-1:0]   toss_i,
    output logic [RESULT_W-1:0] result_o,
    output logic [STREAK_W-1:0] streak_o
);
    game_regs_t regs_d, regs_q;
    logic       is_head, is_tail;

    toss_decoder u_dec (
        .toss_i    (toss_i),
        .is_head_o (is_head),
        .is_tail_o (is_tail)
    );

    game_next_logic u_next (
        .streak_i  (regs_q.streak),
        .is_head_i (is_head),
        .is_tail_i (is_tail),
        .next_o    (regs_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.streak <= ST_ZERO;
            regs_q.result <= RES_NONE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign result_o = regs_q.result;
    assign streak_o = regs_q.streak;

    a_r9_streak_legal: assert property (@(posedge clk) disable iff (rst)
        streak_o != 2'b11);
    a_r3_result_legal: assert property (@(posedge clk) disable iff (rst)
        result_o != 2'b11);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (result_o == 2'b00 && streak_o == 2'b00));
    a_r5_win: assert property (@(posedge clk) disable iff (rst)
        (streak_o == 2'b10 && toss_i == 2'b01) |=> (result_o == 2'b01 && streak_o == 2'b00));
    a_r6_lose: assert property (@(posedge clk) disable iff (rst)
        (toss_i == 2'b10) |=> (result_o == 2'b10 && streak_o == 2'b00));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (toss_i == 2'b00 || toss_i == 2'b11) |=> (result_o == 2'b00 && $stable(streak_o)));
    a_r4_advance: assert property (@(posedge clk) disable iff (rst)
        (toss_i == 2'b01 && streak_o != 2'b10) |=> (result_o == 2'b00 && streak_o == $past(streak_o) + 2'd1));
endmodule

// File: tb/coin_game_fsm_bench.sv
module coin_game_fsm_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] toss;
    logic [1:0] result;
    logic [1:0] streak;
    int checks = 0;
    int errors = 0;
    int m_streak;
    logic [1:0] m_result;

    always #10 clk = ~clk;

    coin_game_fsm u_coin_game_fsm (
        .clk(clk), .rst(rst), .toss_i(toss),
        .result_o(result), .streak_o(streak)
    );

    function automatic logic [1:0] model_result(int s, logic [1:0] t);
        if (t == 2'b10) return 2'b10;
        if (t == 2'b01 && s == 2) return 2'b01;
        return 2'b00;
    endfunction

    function automatic int model_streak(int s, logic [1:0] t);
        if (t == 2'b10) return 0;
        if (t == 2'b01) return (s == 2) ? 0 : s + 1;
        return s;
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    // drive at negedge, sample after the next posedge
    task automatic step(logic [1:0] t, string req);
        toss = t;
        m_result = model_result(m_streak, t);
        m_streak = model_streak(m_streak, t);
        @(posedge clk); #5;
        check(req, result, m_result);
        check(req, streak, 2'(m_streak));
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; toss = 2'b01; m_streak = 0;
        @(negedge clk); @(negedge clk);
        check("R1", result, 2'b00);
        check("R1", streak, 2'b00);
        rst = 1'b0;
        // R8 directed: tail head head head -> lose none none win
        step(2'b10, "R8_R6");
        step(2'b01, "R8_R4");
        step(2'b01, "R8_R4");
        step(2'b01, "R8_R5");
        // R7 gaps mid-streak, R2 code 11
        step(2'b01, "R4");
        step(2'b00, "R7");
        step(2'b11, "R2");
        step(2'b01, "R4");
        step(2'b11, "R7");
        step(2'b01, "R5");
        // back-to-back wins
        for (int i = 0; i < 6; i++) step(2'b01, "R5");
        step(2'b10, "R6");
        step(2'b10, "R6");
        // reset mid-streak
        step(2'b01, "R4");
        rst = 1'b1; toss = 2'b10;
        @(posedge clk); #5;
        check("R1", result, 2'b00);
        check("R1", streak, 2'b00);
        @(negedge clk); rst = 1'b0; m_streak = 0;
        // random streams, heads biased
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            logic [1:0] t = (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : (r == 8) ? 2'b00 : 2'b11;
            step(t, "R3_R9");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule